// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a fixed memory self-test over a power-of-two region of word addresses. It produces the request stream for a simple in-order bus master, and it checks every read-back word against a pattern. It does not build the bus protocol or the memory. It only creates the addresses, burst lengths and data words, then compares what comes back.

A pulse on `start` latches the region size (as log2 of the word count) and a 32-bit seed. The block then waits through a start-up delay. After the delay it steps through seven phases:

- Three short phases. Each one writes a single word and reads it back, item by item, at addresses chosen to hit low words, different banks and the same bank.
- A phase of single-word writes followed by single-word reads.
- A phase that writes the whole region as one burst and reads it back as one burst.
- A phase that writes in 3-word bursts and reads in 13-word bursts.
- A phase that writes and reads with scattered strides.

Test data is a function of the seed, the phase and the address, so expected words are never stored. The first bad read or bus error ends the run and freezes the failing address, the expected word and the returned word. Pass is reported only after all seven phases complete.

Top module: `bist_mem_sequencer`

## Requirements
- R1: After `start` is accepted in idle or done, no request is presented for at least STARTUP_CYCLES clock cycles (default 141195).
- R2: Phases run in the order 1 to 7, and `phase` shows the running phase code. It reads 0 after reset until the first phase begins.
- R3: Phases 1, 2 and 3 each take i = 0..7 in turn. For each i they write one word and then read that word back. The address is i in phase 1, 1087+1031*i in phase 2 and 1109+1024*i in phase 3.
- R4: Phase 4 writes every word 0..N-1 as single-word bursts, then reads every word 0..N-1 as single-word bursts (N = 2^size_log2).
- R5: Phase 5 writes words 0..N-1 as one burst, then reads them as one burst. A burst is presented without gaps except while stalled. A new burst starts only after every response of the previous burst has returned.
- R6: Phase 6 writes ascending addresses in bursts of 3 and then reads them in bursts of 13. The last burst of each pass is shortened to end at N.
- R7: Phase 7 writes the word at (i*3889) mod N for i = 0..N-1, then reads the word at (i*7477) mod N. The modulo is taken by masking.
- R8: The word written to address a in phase p is G(seed ^ (a*32'h9E3779B1) ^ (p<<29)). G shifts its 32-bit argument right by one and XORs in 32'hEDB88320 when the bit shifted out was 1. A read of that address expects the same word.
- R9: Every request address lies inside the region: bits at and above size_log2 are zero. size_log2 is allowed from 4 up to ADDR_W.
- R10: While a request is stalled (`req_valid` high, `req_ready` low), its address, direction and data stay unchanged until it is taken.
- R11: A read response whose data differs from the expected word stops the run. It sets `done`, clears `pass`, issues no further requests, and latches `fail_addr`, `fail_exp` and `fail_got`.
- R12: A response with `rsp_err` high, on a read or a write, stops the run the same way. `fail_got` takes the response data.
- R13: `done` and `pass` clear on an accepted `start`. When a run ends they stay fixed until the next `start`. `pass` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (taken in idle or done) |
| size_log2 | input | $clog2(ADDR_W+1) | Log2 of region size in words |
| seed | input | 32 | Pattern seed |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Master accepts request this cycle |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | In-order response for an earlier request |
| rsp_rdata | input | 32 | Read data of the response |
| rsp_err | input | 1 | Bus error on the response |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no error |
| phase | output | 3 | Current phase code |
| fail_addr | output | ADDR_W | Address of first failure |
| fail_exp | output | 32 | Expected word at failure |
| fail_got | output | 32 | Returned word at failure |

## Verification
The bench targets the end of each pass:
- If the clipping of the 13-word read bursts is wrong, a request runs past N or a chunk is skipped.
- If the write-to-read turnaround is wrong, a read arrives before its burst has been written, or a pass is repeated.
- Strides that are not masked to the region would show up as addresses above N.

The two error runs fail on an early, known address. A sequencer that latched the wrong response index, kept issuing after the failure, or ignored the error flag on write responses reports a wrong failing address or phase, or stays busy.

Stalls are applied throughout every run. A design that moves on while stalled, or starts a burst with responses still outstanding, breaks the per-clock comparison.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_NEXT, ST_ISSUE, ST_DRAIN, ST_DONE
  } bist_state_t;

  localparam logic [2:0] PH_IDLE     = 3'd0;
  localparam logic [2:0] PH_LOW      = 3'd1;
  localparam logic [2:0] PH_BANKS    = 3'd2;
  localparam logic [2:0] PH_SAMEBANK = 3'd3;
  localparam logic [2:0] PH_SINGLE   = 3'd4;
  localparam logic [2:0] PH_STREAM   = 3'd5;
  localparam logic [2:0] PH_CHUNK    = 3'd6;
  localparam logic [2:0] PH_STRIDE   = 3'd7;

  localparam logic [31:0] BANKS_BASE = 32'd1087;
  localparam logic [31:0] BANKS_STEP = 32'd1031;
  localparam logic [31:0] SAME_BASE  = 32'd1109;
  localparam logic [31:0] SAME_STEP  = 32'd1024;
  localparam logic [31:0] WR_STRIDE  = 32'd3889;
  localparam logic [31:0] RD_STRIDE  = 32'd7477;

  localparam int CASE_ITEMS = 8;
  localparam int WR_CHUNK   = 3;
  localparam int RD_CHUNK   = 13;

  localparam logic [31:0] MIX_MULT  = 32'h9E3779B1;
  localparam logic [31:0] LFSR_TAPS = 32'hEDB88320;

endpackage

// File: rtl/bist_addr_gen.sv
module bist_addr_gen
  import bist_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]        phase,
  input  logic              rd,
  input  logic [ADDR_W:0]   idx,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] addr
);
  logic [31:0] idx32;
  logic [31:0] raw;

  assign idx32 = 32'(idx);

  always_comb begin
    case (phase)
      PH_BANKS:    raw = BANKS_BASE + BANKS_STEP * idx32;
      PH_SAMEBANK: raw = SAME_BASE + SAME_STEP * idx32;
      PH_STRIDE:   raw = rd ? (RD_STRIDE * idx32) : (WR_STRIDE * idx32);
      default:     raw = idx32;
    endcase
  end

  assign addr = raw[ADDR_W-1:0] & mask;
endmodule

// File: rtl/bist_pattern.sv
module bist_pattern
  import bist_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [31:0]       seed,
  input  logic [2:0]        phase,
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       word
);
  logic [31:0] mix;

  assign mix  = seed ^ (32'(addr) * MIX_MULT) ^ {phase, 29'd0};
  assign word = {1'b0, mix[31:1]} ^ (mix[0] ? LFSR_TAPS : 32'd0);
endmodule

// File: rtl/bist_mem_sequencer.sv
module bist_mem_sequencer
  import bist_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int STARTUP_CYCLES = 141195,
  localparam int SZ_W  = $clog2(ADDR_W + 1),
  localparam int CNT_W = $clog2(STARTUP_CYCLES + 2),
  localparam int IW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SZ_W-1:0]   size_log2,
  input  logic [31:0]       seed,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata,
  input  logic              rsp_err,
  output logic              done,
  output logic              pass,
  output logic [2:0]        phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [31:0]       fail_exp,
  output logic [31:0]       fail_got
);
  bist_state_t       st;
  logic [CNT_W-1:0]  wait_cnt;
  logic [ADDR_W-1:0] mask_q;
  logic [IW-1:0]     nwords_q, bidx, iidx, ridx, bend, outst;
  logic [31:0]       seed_q;
  logic              rd_q;
  logic [2:0]        ph_q;

  logic              is_case, busy, accept, mismatch;
  logic [IW-1:0]     total, nom_len, remain, blen;
  logic [ADDR_W-1:0] rsp_addr;
  logic [31:0]       exp_word;
  logic [IW-1:0]     region_n;

  logic              adv_end, adv_rd, adv_newph;
  logic [2:0]        adv_ph;
  logic [IW-1:0]     adv_bidx;

  assign is_case  = (ph_q != PH_IDLE) && (ph_q <= PH_SAMEBANK);
  assign busy     = (st == ST_ISSUE) || (st == ST_DRAIN);
  assign accept   = req_valid && req_ready;
  assign region_n = IW'(1) << size_log2;

  assign total   = is_case ? IW'(CASE_ITEMS) : nwords_q;
  assign nom_len = (ph_q == PH_STREAM) ? nwords_q :
                   (ph_q == PH_CHUNK)  ? (rd_q ? IW'(RD_CHUNK) : IW'(WR_CHUNK)) :
                   IW'(1);
  assign remain  = total - bidx;
  assign blen    = (nom_len < remain) ? nom_len : remain;

  // request side address / data
  bist_addr_gen #(.ADDR_W(ADDR_W)) u_issue_addr (
    .phase(ph_q), .rd(rd_q), .idx(iidx), .mask(mask_q), .addr(req_addr)
  );
  bist_pattern #(.ADDR_W(ADDR_W)) u_issue_pat (
    .seed(seed_q), .phase(ph_q), .addr(req_addr), .word(req_wdata)
  );

  // response side: regenerate address and expected word from response index
  bist_addr_gen #(.ADDR_W(ADDR_W)) u_check_addr (
    .phase(ph_q), .rd(rd_q), .idx(ridx), .mask(mask_q), .addr(rsp_addr)
  );
  bist_pattern #(.ADDR_W(ADDR_W)) u_check_pat (
    .seed(seed_q), .phase(ph_q), .addr(rsp_addr), .word(exp_word)
  );

  assign mismatch = rsp_valid && busy && (rsp_err || (rd_q && (rsp_rdata != exp_word)));

  assign req_valid = (st == ST_ISSUE);
  assign req_we    = !rd_q;
  assign phase     = ph_q;

  // where to go after a burst has fully drained
  always_comb begin
    adv_ph    = ph_q;
    adv_rd    = rd_q;
    adv_bidx  = bidx;
    adv_newph = 1'b0;
    adv_end   = 1'b0;
    if (is_case) begin
      if (!rd_q) adv_rd = 1'b1;
      else if (bidx == IW'(CASE_ITEMS - 1)) adv_newph = 1'b1;
      else begin
        adv_rd   = 1'b0;
        adv_bidx = bidx + IW'(1);
      end
    end else if (bend != total) begin
      adv_bidx = bend;
    end else if (!rd_q) begin
      adv_rd   = 1'b1;
      adv_bidx = '0;
    end else begin
      adv_newph = 1'b1;
    end
    if (adv_newph) begin
      if (ph_q == PH_STRIDE) adv_end = 1'b1;
      else begin
        adv_ph   = ph_q + 3'd1;
        adv_rd   = 1'b0;
        adv_bidx = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wait_cnt  <= '0;
      mask_q    <= '0;
      nwords_q  <= '0;
      seed_q    <= '0;
      rd_q      <= 1'b0;
      ph_q      <= PH_IDLE;
      bidx      <= '0;
      iidx      <= '0;
      ridx      <= '0;
      bend      <= '0;
      outst     <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else begin
      if (busy) begin
        case ({accept, rsp_valid})
          2'b10:   outst <= outst + IW'(1);
          2'b01:   outst <= outst - IW'(1);
          default: outst <= outst;
        endcase
        if (rsp_valid) ridx <= ridx + IW'(1);
      end
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            mask_q    <= ADDR_W'(region_n - IW'(1));
            nwords_q  <= region_n;
            seed_q    <= seed;
            wait_cnt  <= CNT_W'(STARTUP_CYCLES);
            outst     <= '0;
            ph_q      <= PH_IDLE;
            rd_q      <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            ph_q <= PH_LOW;
            rd_q <= 1'b0;
            bidx <= '0;
            st   <= ST_NEXT;
          end else begin
            wait_cnt <= wait_cnt - CNT_W'(1);
          end
        end
        ST_NEXT: begin
          iidx <= bidx;
          ridx <= bidx;
          bend <= bidx + blen;
          st   <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (accept) begin
            iidx <= iidx + IW'(1);
            if (iidx + IW'(1) == bend) st <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (outst == '0) begin
            if (adv_end) begin
              done <= 1'b1;
              pass <= 1'b1;
              st   <= ST_DONE;
            end else begin
              ph_q <= adv_ph;
              rd_q <= adv_rd;
              bidx <= adv_bidx;
              st   <= ST_NEXT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (mismatch) begin
        fail_addr <= rsp_addr;
        fail_exp  <= exp_word;
        fail_got  <= rsp_rdata;
        done      <= 1'b1;
        pass      <= 1'b0;
        st        <= ST_DONE;
      end
    end
  end

  AST_REQ_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((req_addr & ~mask_q) == '0)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (done || (req_valid && $stable(req_addr)
      && $stable(req_we) && $stable(req_wdata)))); // R10
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    pass |-> done); // R13
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid); // R11
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_addr))); // R13
  AST_PHASE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (phase != PH_IDLE)); // R2
endmodule

// File: tb/bist_mem_sequencer_bench.sv
`timescale 1ns/1ps
module bist_mem_sequencer_bench;
  localparam int AW = 8;
  localparam int SU = 10;
  localparam int WD = 150000;
  localparam int SZW = $clog2(AW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SZW-1:0] size_log2 = '0;
  logic [31:0] seed = '0;
  logic req_valid, req_we, done, pass;
  logic req_ready = 1'b0;
  logic [AW-1:0] req_addr, fail_addr;
  logic [31:0] req_wdata, fail_exp, fail_got;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic rsp_err = 1'b0;
  logic [2:0] phase;

  always #2.5 clk = ~clk;

  bist_mem_sequencer #(.ADDR_W(AW), .STARTUP_CYCLES(SU)) u_bist_mem_sequencer (
    .clk(clk), .rst(rst), .start(start), .size_log2(size_log2), .seed(seed),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .done(done), .pass(pass),
    .phase(phase), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
  );

  typedef struct { bit we; int addr; logic [31:0] data; bit first; int ph; } req_t;
  typedef struct { logic [31:0] d; bit e; int due; } rsp_t;

  req_t q[$];
  rsp_t rq[$];
  logic [31:0] mem [0:(1<<AW)-1];
  int n_chk = 0, n_bad = 0, cyc = 0, n_acc = 0, n_rsp = 0, start_cyc = 0;
  int cur_n = 16;
  bit running = 0, first_seen = 0;
  bit corrupt_en = 0, err_en = 0;
  int corrupt_addr = 0, err_addr = 0;
  bit prev_valid = 0, prev_ready = 0;
  logic [AW-1:0] prev_addr;
  logic [31:0] prev_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] sd, input int p, input int a);
    logic [31:0] m;
    m = sd ^ (32'(a) * 32'h9E3779B1) ^ (32'(p) << 29);
    return (m >> 1) ^ (m[0] ? 32'hEDB88320 : 32'd0);
  endfunction

  function automatic string tag(input int p);
    if (p <= 3) return "R3";
    if (p == 4) return "R4";
    if (p == 5) return "R5";
    if (p == 6) return "R6";
    return "R7";
  endfunction

  task automatic push(input bit we, input int a, input int p, input bit first, input logic [31:0] sd);
    req_t r;
    r.we = we; r.addr = a; r.ph = p; r.first = first; r.data = pat(sd, p, a);
    q.push_back(r);
  endtask

  task automatic build(input int sz, input logic [31:0] sd);
    int n, m;
    n = 1 << sz; m = n - 1; cur_n = n;
    q.delete();
    for (int p = 1; p <= 3; p++)
      for (int i = 0; i < 8; i++) begin
        int a;
        a = (p == 1) ? i : (p == 2) ? (1087 + 1031 * i) : (1109 + 1024 * i);
        a = a & m;
        push(1, a, p, 1, sd);
        push(0, a, p, 1, sd);
      end
    for (int i = 0; i < n; i++) push(1, i, 4, 1, sd);
    for (int i = 0; i < n; i++) push(0, i, 4, 1, sd);
    for (int i = 0; i < n; i++) push(1, i, 5, i == 0, sd);
    for (int i = 0; i < n; i++) push(0, i, 5, i == 0, sd);
    for (int i = 0; i < n; i++) push(1, i, 6, (i % 3) == 0, sd);
    for (int i = 0; i < n; i++) push(0, i, 6, (i % 13) == 0, sd);
    for (int i = 0; i < n; i++) push(1, (i * 3889) & m, 7, 1, sd);
    for (int i = 0; i < n; i++) push(0, (i * 7477) & m, 7, 1, sd);
  endtask

  // per-clock reference: bus model plus expected request stream
  always @(negedge clk) begin
    int outst_b;
    bit rdy;
    cyc++;
    if (cyc >= WD) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (!rst) begin
      outst_b = n_acc - n_rsp;
      rdy = (cyc % 5) != 3;
      req_ready = rdy;
      if (prev_valid && !prev_ready && !done)
        chk(req_valid && req_addr == prev_addr && req_wdata == prev_data,
            "R10", "stalled request changed", {32'(req_addr), req_wdata}, {32'(prev_addr), prev_data});
      if (req_valid) begin
        if (running && !first_seen) begin
          first_seen = 1;
          chk((cyc - start_cyc) >= SU, "R1", "start-up delay", cyc - start_cyc, SU);
        end
        chk(32'(req_addr) < cur_n, "R9", "address outside region", req_addr, cur_n);
        if (q.size() == 0) begin
          chk(0, "R2", "request after sequence end", req_addr, 0);
        end else begin
          chk(phase == 3'(q[0].ph), "R2", "phase code", phase, q[0].ph);
          chk(req_we == q[0].we && 32'(req_addr) == q[0].addr, tag(q[0].ph), "request dir/addr",
              {31'd0, req_we, 32'(req_addr)}, {31'd0, q[0].we, 32'(q[0].addr)});
          if (q[0].we)
            chk(req_wdata == q[0].data, "R8", "write data", req_wdata, q[0].data);
          if (q[0].first)
            chk(outst_b == 0, "R5", "burst start with responses pending", outst_b, 0);
          if (rdy) begin
            rsp_t r;
            r.due = cyc + 2;
            r.e = err_en && (32'(req_addr) == err_addr);
            if (req_we) begin
              mem[req_addr] = req_wdata;
              r.d = '0;
            end else begin
              r.d = mem[req_addr] ^ ((corrupt_en && 32'(req_addr) == corrupt_addr) ? 32'd1 : 32'd0);
            end
            rq.push_back(r);
            q.pop_front();
            n_acc++;
          end
        end
      end else if (running && !done && q.size() > 0) begin
        chk(q[0].first, "R5", "gap inside a burst", 0, 1);
      end
      prev_valid = req_valid; prev_ready = rdy; prev_addr = req_addr; prev_data = req_wdata;
      if (rq.size() > 0 && rq[0].due <= cyc) begin
        rsp_valid = 1; rsp_rdata = rq[0].d; rsp_err = rq[0].e;
        rq.pop_front();
        n_rsp++;
      end else begin
        rsp_valid = 0; rsp_err = 0; rsp_rdata = '0;
      end
    end
  end

  task automatic run(input int sz, input logic [31:0] sd, input bit exp_pass, input string rtag,
                     input int f_addr, input logic [31:0] f_exp, input logic [31:0] f_got);
    build(sz, sd);
    @(negedge clk);
    size_log2 = SZW'(sz); seed = sd; start = 1; start_cyc = cyc; first_seen = 0; running = 1;
    @(negedge clk);
    start = 0;
    chk(!done && !pass, "R13", "done/pass clear after start", {done, pass}, 0);
    while (!done) @(negedge clk);
    running = 0;
    chk(pass == exp_pass, exp_pass ? "R13" : rtag, "pass flag", pass, exp_pass);
    if (exp_pass) begin
      chk(q.size() == 0, "R2", "requests left unissued", q.size(), 0);
    end else begin
      chk(32'(fail_addr) == f_addr, rtag, "fail_addr", fail_addr, f_addr);
      chk(fail_exp == f_exp, rtag, "fail_exp", fail_exp, f_exp);
      chk(fail_got == f_got, rtag, "fail_got", fail_got, f_got);
      chk(phase == 3'd1, rtag, "phase at failure", phase, 1);
    end
    repeat (8) @(negedge clk);
    chk(done && pass == exp_pass && !req_valid, "R13", "result held",
        {req_valid, done, pass}, {1'b0, 1'b1, exp_pass});
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!done && !pass && !req_valid, "R13", "reset outputs", {req_valid, done, pass}, 0);
    chk(phase == 3'd0, "R2", "reset phase", phase, 0);
    run(4, 32'h1234_5678, 1, "R13", 0, 0, 0);
    corrupt_en = 1; corrupt_addr = 5;
    run(4, 32'hCAFE_0001, 0, "R11", 5, pat(32'hCAFE_0001, 1, 5), pat(32'hCAFE_0001, 1, 5) ^ 32'd1);
    corrupt_en = 0;
    err_en = 1; err_addr = 3;
    run(5, 32'h0BAD_F00D, 0, "R12", 3, pat(32'h0BAD_F00D, 1, 3), 32'd0);
    err_en = 0;
    run(5, 32'hA5A5_0F0F, 1, "R13", 0, 0, 0);
    run(6, 32'h0000_0001, 1, "R13", 0, 0, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule